// File: doc/BRIEF.md
# Microprogram Sequencer with Bit-ORed Branching

This block is the control side of a microprogrammed processor. It holds a small control store, a microprogram counter and a starting-address generator that looks at the instruction register. Each cycle it presents the control word at the current micro-address. The word is decoded into one-hot bus-source enables, a register load mask, a one-hot ALU operation and single-bit memory and sequencing strobes.

It then picks the next micro-address. The choices are the incremented address, a fixed target, the start address of the instruction in IR, or a target whose low bits are ORed with addressing-mode bits from IR. With this ORing, several addressing-mode routines can share a common tail. It also lets a direct operand skip the indirect step.

A word that carries the wait flag stalls the counter until the memory reports completion. The datapath and the instruction memory sit outside the block. IR, the negative flag and the memory-complete input come from the surrounding processor.

Top module: `useq_top`

## Requirements
- R1: While reset is low and in the first cycle after it, the micro-address is octal 000. The controls at 000 are: PC out-enable (outEn bit 1), MAR and Z loads (loadEn bits 1 and 3), ALU add (aluSel bit 1) with the constant-4 A input, and a memory read.
- R2: When the current word has no branch, no End and no pending wait, the micro-address goes up by one per clock. The fetch sequence therefore runs 000, 001, 002, 003.
- R3: A word with the wait flag drives waitOut high and holds the micro-address while mfc is low at a clock edge. On the first edge with mfc high it leaves by its normal rule. The wait words are at 001, 111, 122, 142, 161 and 170.
- R4: At 003, opcode IR[15:11] = 00010 dispatches to octal 101. IR[10:9] is ORed into address bits 5:4, and (IR[10:9] = 00 and IR[8]) is ORed into bit 3, so the entries are 101, 111, 121, 141 and 161.
- R5: At 003, opcode 00011 dispatches to decimal 25. Any other opcode returns to 000.
- R6: Entry 101 jumps to 172. Entries 111 and 161 branch at once. Entries 121 and 141 first pass through 122 and 142. These branches target 170 with IR[8] ORed into bit 0, so IR[8] = 0 reaches 170 and IR[8] = 1 reaches 171. 170 falls through to 171, then 172 and 173.
- R7: The words at 173 and at decimal 27 raise endOut, and the next micro-address is 000. On every other word on these paths endOut is low.
- R8: At decimal 25, a negative flag of 0 jumps to 000. A flag of 1 continues to 26 and then 27.
- R9: Source code k sets only outEn bit k (1 PC, 2 Z, 3 MDR, 4 Rsrc, 5 Rdst, 6 offset). The load mask bit order is PC 0, MAR 1, Y 2, Z 3, IR 4, Rsrc 5, Rdst 6, MDR 7. At 173 only outEn bit 2 and loadEn bit 6 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ir | input | 16 | Instruction register contents |
| flagN | input | 1 | Negative condition flag |
| mfc | input | 1 | Memory operation complete |
| upc | output | 7 | Current micro-address |
| outEn | output | 8 | One-hot bus source enables |
| loadEn | output | 8 | Register load mask |
| aluSel | output | 16 | One-hot ALU operation |
| selConst4 | output | 1 | ALU A input takes constant 4 instead of Y |
| memRead | output | 1 | Memory read request |
| memWrite | output | 1 | Memory write request |
| endOut | output | 1 | End of machine instruction |
| waitOut | output | 1 | Current word waits for mfc |

## Verification
Every control output is a pure function of the micro-address. A wrong counter value, dispatch or ORed bit therefore shows up on upc and the control lines in the very next cycle. A missed stall shows up as upc moving while waitOut is high and mfc is low. A wrong mode ORing sends the address to the wrong routine entry one cycle after 003. A wrong IR[8] ORing shows as a stop at 170 for a direct operand, or a skip of it for an indirect one. The bench therefore follows the full expected address trace for every mode, both flag values and several memory latencies, and compares upc on every cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int AW   = 7;
  parameter int IRW  = 16;
  parameter int SRCW = 3;
  parameter int LDW  = 8;
  parameter int ALUW = 4;
  localparam int NSRC = 1 << SRCW;
  localparam int NALU = 1 << ALUW;
  localparam int OPW  = 5;
  localparam int OP_LSB = IRW - OPW;
  localparam int MODE_LSB = 8;

  typedef logic [AW-1:0] uaddr_t;

  typedef enum logic [2:0] {
    BR_NONE, BR_WIDE, BR_JUMP, BR_OR8, BR_NZERO
  } brKind_e;

  typedef struct packed {
    logic [SRCW-1:0] src;
    logic [LDW-1:0]  load;
    logic [ALUW-1:0] alu;
    logic            selK;
    logic            rd;
    logic            wr;
    logic            wmfc;
    logic            fin;
    brKind_e         br;
    uaddr_t          tgt;
  } uword_t;

  // strobes from the word store/decoder side to the sequencer
  typedef struct packed {
    logic    wmfc;
    logic    fin;
    brKind_e br;
    uaddr_t  tgt;
  } seqStrb_t;

  localparam uaddr_t A_FETCH = 'o000;
  localparam uaddr_t A_ADD   = 'o101;
  localparam uaddr_t A_BRN   = 25;
  localparam uaddr_t A_IND   = 'o170;
  localparam uaddr_t A_TAIL  = 'o172;

  localparam logic [OPW-1:0] OP_ADD = 5'b00010;
  localparam logic [OPW-1:0] OP_BRN = 5'b00011;

  localparam logic [SRCW-1:0] S_NONE = 0, S_PC = 1, S_Z = 2, S_MDR = 3,
                              S_RSRC = 4, S_RDST = 5, S_OFS = 6;
  localparam logic [LDW-1:0] LD_PC = 8'h01, LD_MAR = 8'h02, LD_Y = 8'h04,
                             LD_Z = 8'h08, LD_IR = 8'h10, LD_RSRC = 8'h20,
                             LD_RDST = 8'h40;
  localparam logic [ALUW-1:0] ALU_PASS = 0, ALU_ADD = 1, ALU_SUB = 2;
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  uaddr_t upc,
  output uword_t word
);
  function automatic uword_t mk(logic [SRCW-1:0] s, logic [LDW-1:0] l,
                                logic [ALUW-1:0] a, logic k, logic r,
                                logic w, logic wt, logic fn, brKind_e b,
                                uaddr_t t);
    mk = '{src:s, load:l, alu:a, selK:k, rd:r, wr:w, wmfc:wt, fin:fn, br:b, tgt:t};
  endfunction

  always_comb begin
    case (upc)
      'o000: word = mk(S_PC,   LD_MAR | LD_Z,    ALU_ADD,  1, 1, 0, 0, 0, BR_NONE,  '0);
      'o001: word = mk(S_Z,    LD_PC | LD_Y,     ALU_PASS, 0, 0, 0, 1, 0, BR_NONE,  '0);
      'o002: word = mk(S_MDR,  LD_IR,            ALU_PASS, 0, 0, 0, 0, 0, BR_NONE,  '0);
      'o003: word = mk(S_NONE, '0,               ALU_PASS, 0, 0, 0, 0, 0, BR_WIDE,  '0);
      25:    word = mk(S_NONE, '0,               ALU_PASS, 0, 0, 0, 0, 0, BR_NZERO, A_FETCH);
      26:    word = mk(S_OFS,  LD_Z,             ALU_ADD,  0, 0, 0, 0, 0, BR_NONE,  '0);
      27:    word = mk(S_Z,    LD_PC,            ALU_PASS, 0, 0, 0, 0, 1, BR_NONE,  '0);
      'o101: word = mk(S_RSRC, LD_Y,             ALU_PASS, 0, 0, 0, 0, 0, BR_JUMP,  A_TAIL);
      'o111: word = mk(S_RSRC, LD_MAR,           ALU_PASS, 0, 1, 0, 1, 0, BR_OR8,   A_IND);
      'o121: word = mk(S_RSRC, LD_MAR | LD_Z,    ALU_ADD,  1, 1, 0, 0, 0, BR_NONE,  '0);
      'o122: word = mk(S_Z,    LD_RSRC,          ALU_PASS, 0, 0, 0, 1, 0, BR_OR8,   A_IND);
      'o141: word = mk(S_RSRC, LD_Z,             ALU_SUB,  1, 0, 0, 0, 0, BR_NONE,  '0);
      'o142: word = mk(S_Z,    LD_RSRC | LD_MAR, ALU_PASS, 0, 1, 0, 1, 0, BR_OR8,   A_IND);
      'o161: word = mk(S_RSRC, LD_MAR,           ALU_PASS, 0, 1, 0, 1, 0, BR_OR8,   A_IND);
      'o170: word = mk(S_MDR,  LD_MAR,           ALU_PASS, 0, 1, 0, 1, 0, BR_NONE,  '0);
      'o171: word = mk(S_MDR,  LD_Y,             ALU_PASS, 0, 0, 0, 0, 0, BR_NONE,  '0);
      'o172: word = mk(S_RDST, LD_Z,             ALU_ADD,  0, 0, 0, 0, 0, BR_NONE,  '0);
      'o173: word = mk(S_Z,    LD_RDST,          ALU_PASS, 0, 0, 0, 0, 1, BR_NONE,  '0);
      default: word = mk(S_NONE, '0,             ALU_PASS, 0, 0, 0, 0, 1, BR_NONE,  '0);
    endcase
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  uword_t          word,
  output logic [NSRC-1:0] outEn,
  output logic [LDW-1:0]  loadEn,
  output logic [NALU-1:0] aluSel,
  output logic            selConst4,
  output logic            memRead,
  output logic            memWrite,
  output logic            endOut,
  output logic            waitOut
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == 0) begin : g_none
      assign outEn[g] = 1'b0;
    end else begin : g_line
      assign outEn[g] = (word.src == SRCW'(g));
    end
  end

  for (genvar g = 0; g < NALU; g++) begin : g_alu
    assign aluSel[g] = (word.alu == ALUW'(g));
  end

  assign loadEn    = word.load;
  assign selConst4 = word.selK;
  assign memRead   = word.rd;
  assign memWrite  = word.wr;
  assign endOut    = word.fin;
  assign waitOut   = word.wmfc;
endmodule

// File: rtl/useq_seq.sv
module useq_seq
  import useq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  seqStrb_t       strb,
  input  logic [IRW-1:0] ir,
  input  logic           flagN,
  input  logic           mfc,
  output uaddr_t         upc
);
  logic [OPW-1:0] opcode;
  logic [2:0]     mode;
  uaddr_t         startAddr, modeBits, incAddr, nextAddr;
  logic           stall;

  assign opcode  = ir[IRW-1:OP_LSB];
  assign mode    = ir[MODE_LSB+2:MODE_LSB];
  assign incAddr = upc + 1'b1;
  assign stall   = strb.wmfc & ~mfc;

  // starting-address generator with mode-bit ORing
  always_comb begin
    startAddr = A_FETCH;
    modeBits  = '0;
    case (opcode)
      OP_ADD: begin
        startAddr   = A_ADD;
        modeBits[5:4] = mode[2:1];
        modeBits[3]   = (mode[2:1] == 2'b00) & mode[0];
      end
      OP_BRN:  startAddr = A_BRN;
      default: startAddr = A_FETCH;
    endcase
  end

  always_comb begin
    if (stall) begin
      nextAddr = upc;
    end else if (strb.fin) begin
      nextAddr = A_FETCH;
    end else begin
      case (strb.br)
        BR_WIDE:  nextAddr = startAddr | modeBits;
        BR_JUMP:  nextAddr = strb.tgt;
        BR_OR8:   nextAddr = strb.tgt | uaddr_t'(mode[0]);
        BR_NZERO: nextAddr = flagN ? incAddr : strb.tgt;
        default:  nextAddr = incAddr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) upc <= A_FETCH;
    else       upc <= nextAddr;
  end

  p_incr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.br == BR_NONE && !strb.fin && !strb.wmfc) |=> upc == uaddr_t'($past(upc) + 1'b1));

  p_hold_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wmfc && !mfc) |=> $stable(upc));

  p_end_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fin && !strb.wmfc) |=> upc == A_FETCH);

  p_ind_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.br == BR_OR8 && !stall) |=> upc[0] == $past(ir[MODE_LSB]));

  p_nzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.br == BR_NZERO && !strb.fin && !stall && !flagN) |=> upc == A_FETCH);
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [IRW-1:0]  ir,
  input  logic            flagN,
  input  logic            mfc,
  output logic [AW-1:0]   upc,
  output logic [NSRC-1:0] outEn,
  output logic [LDW-1:0]  loadEn,
  output logic [NALU-1:0] aluSel,
  output logic            selConst4,
  output logic            memRead,
  output logic            memWrite,
  output logic            endOut,
  output logic            waitOut
);
  uword_t   word;
  seqStrb_t strb;

  useq_store u_store (.upc(upc), .word(word));

  assign strb = '{wmfc:word.wmfc, fin:word.fin, br:word.br, tgt:word.tgt};

  useq_seq u_seq (
    .clk(clk), .rstN(rstN), .strb(strb), .ir(ir),
    .flagN(flagN), .mfc(mfc), .upc(upc)
  );

  useq_decode u_dec (
    .word(word), .outEn(outEn), .loadEn(loadEn), .aluSel(aluSel),
    .selConst4(selConst4), .memRead(memRead), .memWrite(memWrite),
    .endOut(endOut), .waitOut(waitOut)
  );
endmodule

// File: tb/useq_top_tb_top.sv
module useq_top_tb_top;
  typedef struct {
    int         addr;
    logic [15:0] irv;
    logic       nv;
    int         lat;
    logic       expEnd;
    logic       expWait;
    string      tag;
  } item_t;

  item_t sbq[$];
  int checks = 0, errors = 0;
  logic [15:0] curIr;
  logic curN;
  int curLat;
  bit done = 0;

  logic clk = 0, rstN, flagN, mfc;
  logic [15:0] ir;
  logic [6:0] upc;
  logic [7:0] outEn, loadEn;
  logic [15:0] aluSel;
  logic selConst4, memRead, memWrite, endOut, waitOut;

  always #4 clk = ~clk;

  useq_top dut_i (
    .clk(clk), .rstN(rstN), .ir(ir), .flagN(flagN), .mfc(mfc), .upc(upc),
    .outEn(outEn), .loadEn(loadEn), .aluSel(aluSel), .selConst4(selConst4),
    .memRead(memRead), .memWrite(memWrite), .endOut(endOut), .waitOut(waitOut)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0o expected=%0o", tag, what, act, exp);
    end
  endtask

  // driver side: expected trace items
  task automatic step(int a, bit w, bit e, string tag);
    item_t it;
    it = '{addr:a, irv:curIr, nv:curN, lat:curLat, expEnd:e, expWait:w, tag:tag};
    for (int i = 0; i < (w ? curLat + 1 : 1); i++) sbq.push_back(it);
  endtask

  task automatic fetch(string firstTag);
    step('o000, 0, 0, firstTag);
    step('o001, 1, 0, "R2");
    step('o002, 0, 0, "R2");
    step('o003, 0, 0, "R2");
  endtask

  task automatic runAdd(logic [2:0] mode, int lat, string firstTag);
    logic [6:0] e;
    curIr = {5'b00010, mode, 4'h5, 4'h3};
    curN = 0;
    curLat = lat;
    e = 7'o101 | {1'b0, mode[2:1], 4'b0} | {3'b0, (mode[2:1] == 2'b00) & mode[0], 3'b0};
    fetch(firstTag);
    if (e == 7'o101) begin
      step(e, 0, 0, "R4");
    end else if (e == 7'o111 || e == 7'o161) begin
      step(e, 1, 0, "R4");
    end else begin
      step(e, 0, 0, "R4");
      step(e + 1, 1, 0, "R6");
    end
    if (e != 7'o101) begin
      if (!mode[0]) step('o170, 1, 0, "R6");
      step('o171, 0, 0, "R6");
    end
    step('o172, 0, 0, "R6");
    step('o173, 0, 1, "R7");
  endtask

  task automatic runBr(logic n, string firstTag);
    curIr = {5'b00011, 11'h000};
    curN = n;
    curLat = 1;
    fetch(firstTag);
    step(25, 0, 0, "R5");
    if (n) begin
      step(26, 0, 0, "R8");
      step(27, 0, 1, "R8");
    end
  endtask

  task automatic runOther(string firstTag);
    curIr = {5'b10110, 11'h2a5};
    curN = 1;
    curLat = 0;
    fetch(firstTag);
  endtask

  initial begin
    for (int m = 0; m < 8; m++) runAdd(3'(m), m % 3, (m == 0) ? "R2" : "R7");
    runBr(1'b0, "R7");
    runBr(1'b1, "R8");
    runOther("R7");
    runAdd(3'b001, 3, "R5");
    runAdd(3'b110, 0, "R7");
    curIr = 16'h0; curN = 0; curLat = 0;
    step('o000, 0, 0, "R7");
  end

  // monitor side: pops expected items and models memory completion
  initial begin
    item_t it;
    int waitCnt = 0;
    rstN = 0; ir = 16'h0; flagN = 0; mfc = 0;
    repeat (3) @(negedge clk);
    chk(upc == 7'o000, "R1", "reset upc", int'(upc), 0);
    chk(outEn == 8'h02, "R1", "reset outEn", int'(outEn), 'h02);
    chk(loadEn == 8'h0A, "R1", "reset loadEn", int'(loadEn), 'h0A);
    chk(aluSel == 16'h0002, "R1", "reset aluSel", int'(aluSel), 'h2);
    chk(selConst4 && memRead && !memWrite, "R1", "reset k4/rd/wr",
        int'({selConst4, memRead, memWrite}), 'b110);
    rstN = 1;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      chk(int'(upc) == it.addr, it.tag, "upc", int'(upc), it.addr);
      chk(endOut == it.expEnd, "R7", "endOut", int'(endOut), int'(it.expEnd));
      chk(waitOut == it.expWait, "R3", "waitOut", int'(waitOut), int'(it.expWait));
      if (it.addr == 'o173)
        chk(outEn == 8'h04 && loadEn == 8'h40, "R9", "decode at 173",
            int'({outEn, loadEn}), 'h0440);
      ir = it.irv;
      flagN = it.nv;
      if (waitOut) begin
        mfc = (waitCnt == it.lat);
        waitCnt = mfc ? 0 : waitCnt + 1;
      end else begin
        mfc = 0;
        waitCnt = 0;
      end
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=trace complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule